// File: doc/BRIEF.md
# Two-Source Interrupt Status Combiner

This block merges two independent event sources, a hash engine and a DMA engine, into a single level-sensitive interrupt request. Each source reports events as single-cycle pulses. Every pulse latches into a sticky status bit of that source. The status bit stays set until software writes a 1 to it. Each source also has an enable register that picks which latched bits can raise the request. The DMA side has one more global gate, a mask bit. The request stays low for DMA events until that bit is set.

Software reaches the registers over a simple register bus. A write strobe takes a byte address and a 32-bit data word. A read strobe returns data one cycle later, marked by a valid flag. The bus has no back-pressure: a read strobe is always accepted, and its data always arrives on the following cycle. The event inputs and the request output are plain level and pulse pins with no handshake. Software polls the status registers whether or not the matching enables are set.

Top module: `irq_combiner`

## Requirements
- R1: After reset, every status, enable and mask register reads 0 and `irq` is low.
- R2: An event pulse on a hash bit (bits 0..3; bit 2 is the done event, bits 0, 1 and 3 are errors) sets that status bit on the next clock edge, even when its enable bit is clear. A status bit never sets without an event.
- R3: The DMA status register latches events on bits 0 (source transfer done) and 2..8 (errors). Bit 1 is not implemented: it reads 0 and ignores events, enable writes and clear writes.
- R4: Writing a word to a status register clears every bit written as 1 and leaves every bit written as 0. Writing all ones clears every pending bit.
- R5: If an event pulse and a clear write hit the same status bit in the same cycle, the bit stays set.
- R6: `irq` is high exactly while (hash status AND hash enable) is nonzero, or while (DMA status AND DMA enable) is nonzero with the mask bit set. It follows register state in the same cycle, with no extra delay.
- R7: Only bit 0 of the DMA mask register is stored. It must be 1 for DMA status to reach `irq`. The other bits of that register read 0.
- R8: A write to an enable register replaces all of its implemented bits. Writing 0 stops that source from raising `irq`, but its status bits stay latched.
- R9: Register byte offsets: hash status 0x50, hash enable 0x54, DMA status 0x480, DMA enable 0x484, DMA mask 0x488. A read strobe returns `reg_rdata` with `reg_rvalid` high on the next cycle. An unmapped address reads 0.
- R10: A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hash_evt | input | 4 | Hash engine event pulses, one per status bit |
| dma_evt | input | 9 | DMA engine event pulses, one per status bit |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_ren | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid when reg_rvalid is high |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_ren |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
An event pulse or register write captured at edge N shows up in status and in `irq` right after edge N. The bench drives each stimulus just after an edge and samples `irq` at the following falling edge. A read strobe captured at edge N yields data after edge N. The driver queues the expected word and its requirement tag when it issues the read, and a monitor pops and compares at each falling edge where `reg_rvalid` is high. Any valid cycle with nothing queued counts as a failure.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_HSTAT = 3'd1,
    SEL_HEN   = 3'd2,
    SEL_DSTAT = 3'd3,
    SEL_DEN   = 3'd4,
    SEL_DMASK = 3'd5
  } reg_sel_e;

  function automatic logic [31:0] zext_bits(input logic [31:0] v, input int unsigned w);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (i < int'(w)) ? v[i] : 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_combiner_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned OFF_HSTAT = 12'h050,
  parameter int unsigned OFF_HEN   = 12'h054,
  parameter int unsigned OFF_DSTAT = 12'h480,
  parameter int unsigned OFF_DEN   = 12'h484,
  parameter int unsigned OFF_DMASK = 12'h488
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam logic [ADDR_W-1:0] A_HSTAT = ADDR_W'(OFF_HSTAT);
  localparam logic [ADDR_W-1:0] A_HEN   = ADDR_W'(OFF_HEN);
  localparam logic [ADDR_W-1:0] A_DSTAT = ADDR_W'(OFF_DSTAT);
  localparam logic [ADDR_W-1:0] A_DEN   = ADDR_W'(OFF_DEN);
  localparam logic [ADDR_W-1:0] A_DMASK = ADDR_W'(OFF_DMASK);

  always_comb begin
    unique case (addr)
      A_HSTAT: sel = SEL_HSTAT;
      A_HEN:   sel = SEL_HEN;
      A_DSTAT: sel = SEL_DSTAT;
      A_DEN:   sel = SEL_DEN;
      A_DMASK: sel = SEL_DMASK;
      default: sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned    W    = 4,
  parameter logic [W-1:0]   IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         stat_we,
  input  logic         en_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat,
  output logic [W-1:0] en,
  output logic         pend
);

  logic [W-1:0] clr_bits;
  logic [W-1:0] stat_nxt;

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      if (IMPL[b]) begin : g_impl
        assign clr_bits[b] = stat_we & wdata[b];
        // event has priority over a clear in the same cycle
        assign stat_nxt[b] = evt[b] | (stat[b] & ~clr_bits[b]);

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stat[b] <= 1'b0;
            en[b]   <= 1'b0;
          end else begin
            stat[b] <= stat_nxt[b];
            if (en_we) en[b] <= wdata[b];
          end
        end
      end else begin : g_hole
        assign clr_bits[b] = 1'b0;
        assign stat_nxt[b] = 1'b0;
        assign stat[b]     = 1'b0;
        assign en[b]       = 1'b0;
      end
    end
  endgenerate

  assign pend = |(stat & en);

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & IMPL)) |=> ((stat & $past(evt & IMPL)) == $past(evt & IMPL)));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~$past(stat) & ~$past(evt)) == '0));

  // R4
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> ((stat & $past(wdata & ~evt)) == '0));

  // R8
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en == $past(wdata & IMPL)));

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_combiner_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned HASH_W    = 4,
  parameter int unsigned DMA_W     = 9,
  parameter logic [HASH_W-1:0] HASH_IMPL = 4'b1111,
  parameter logic [DMA_W-1:0]  DMA_IMPL  = 9'h1FD,
  parameter int unsigned OFF_HSTAT = 12'h050,
  parameter int unsigned OFF_HEN   = 12'h054,
  parameter int unsigned OFF_DSTAT = 12'h480,
  parameter int unsigned OFF_DEN   = 12'h484,
  parameter int unsigned OFF_DMASK = 12'h488
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HASH_W-1:0] hash_evt,
  input  logic [DMA_W-1:0]  dma_evt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_ren,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              irq
);

  reg_sel_e          sel;
  logic [HASH_W-1:0] h_stat, h_en;
  logic [DMA_W-1:0]  d_stat, d_en;
  logic              h_pend, d_pend;
  logic              mask_q;
  logic [DATA_W-1:0] rd_mux;

  irq_addr_dec #(
    .ADDR_W(ADDR_W), .OFF_HSTAT(OFF_HSTAT), .OFF_HEN(OFF_HEN),
    .OFF_DSTAT(OFF_DSTAT), .OFF_DEN(OFF_DEN), .OFF_DMASK(OFF_DMASK)
  ) u_dec (
    .addr(reg_addr),
    .sel (sel)
  );

  irq_src_bank #(.W(HASH_W), .IMPL(HASH_IMPL)) u_hash (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (hash_evt),
    .stat_we(reg_wen && sel == SEL_HSTAT),
    .en_we  (reg_wen && sel == SEL_HEN),
    .wdata  (reg_wdata[HASH_W-1:0]),
    .stat   (h_stat),
    .en     (h_en),
    .pend   (h_pend)
  );

  irq_src_bank #(.W(DMA_W), .IMPL(DMA_IMPL)) u_dma (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (dma_evt),
    .stat_we(reg_wen && sel == SEL_DSTAT),
    .en_we  (reg_wen && sel == SEL_DEN),
    .wdata  (reg_wdata[DMA_W-1:0]),
    .stat   (d_stat),
    .en     (d_en),
    .pend   (d_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= 1'b0;
    else if (reg_wen && sel == SEL_DMASK) mask_q <= reg_wdata[0];
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_HSTAT: rd_mux[HASH_W-1:0] = h_stat;
      SEL_HEN:   rd_mux[HASH_W-1:0] = h_en;
      SEL_DSTAT: rd_mux[DMA_W-1:0]  = d_stat;
      SEL_DEN:   rd_mux[DMA_W-1:0]  = d_en;
      SEL_DMASK: rd_mux[0]          = mask_q;
      default:   rd_mux             = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_ren;
      if (reg_ren) reg_rdata <= rd_mux;
    end
  end

  assign irq = h_pend | (d_pend & mask_q);

  // R9
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ren |=> reg_rvalid);

  // R9
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_ren |=> !reg_rvalid);

  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_en == '0 && !mask_q) |-> !irq);

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((h_stat & h_en) != '0 || (d_stat & d_en) != '0));

endmodule

// File: tb/tb_irq_combiner.sv
module tb_irq_combiner;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  localparam logic [11:0] A_HSTAT = 12'h050;
  localparam logic [11:0] A_HEN   = 12'h054;
  localparam logic [11:0] A_DSTAT = 12'h480;
  localparam logic [11:0] A_DEN   = 12'h484;
  localparam logic [11:0] A_DMASK = 12'h488;
  localparam logic [11:0] A_HOLE  = 12'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  hash_evt = '0;
  logic [8:0]  dma_evt = '0;
  logic [11:0] reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ren = 1'b0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_combiner dut (
    .clk(clk), .rst_n(rst_n), .hash_evt(hash_evt), .dma_evt(dma_evt),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_ren(reg_ren), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq(irq)
  );

  // monitor: compare read responses against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data: actual %h expected none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s: read actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    cyc();
    reg_wen = 1'b0;
  endtask

  task automatic evt(input logic [3:0] h, input logic [8:0] d);
    hash_evt = h; dma_evt = d;
    cyc();
    hash_evt = '0; dma_evt = '0;
  endtask

  task automatic evt_wr(input logic [3:0] h, input logic [8:0] d,
                        input logic [11:0] a, input logic [31:0] w);
    hash_evt = h; dma_evt = d;
    reg_addr = a; reg_wdata = w; reg_wen = 1'b1;
    cyc();
    hash_evt = '0; dma_evt = '0; reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_addr = a; reg_ren = 1'b1;
    cyc();
    reg_ren = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
    #1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(A_HSTAT, 32'h0, "R1 hash status");
    rd(A_HEN,   32'h0, "R1 hash enable");
    rd(A_DSTAT, 32'h0, "R1 dma status");
    rd(A_DEN,   32'h0, "R1 dma enable");
    rd(A_DMASK, 32'h0, "R1 dma mask");

    // R2 latch while disabled
    evt(4'b0100, '0);
    chk_irq(1'b0, "R2 disabled done event keeps irq low");
    rd(A_HSTAT, 32'h4, "R2 done bit latched");

    // R6 / R8 enable gating
    wr(A_HEN, 32'h4);
    chk_irq(1'b1, "R6 hash done enabled");
    wr(A_HEN, 32'h0);
    chk_irq(1'b0, "R8 zero enable stops irq");
    rd(A_HEN, 32'h0, "R8 enable readback");
    rd(A_HSTAT, 32'h4, "R8 status stays latched");

    // R4 partial and full clear
    evt(4'b1011, '0);
    rd(A_HSTAT, 32'hF, "R2 error bits latched");
    wr(A_HSTAT, 32'h3);
    rd(A_HSTAT, 32'hC, "R4 partial clear");
    wr(A_HSTAT, 32'hFFFF_FFFF);
    rd(A_HSTAT, 32'h0, "R4 clear all");

    // R5 event wins over clear
    evt(4'b1000, '0);
    evt_wr(4'b1000, '0, A_HSTAT, 32'hF);
    rd(A_HSTAT, 32'h8, "R5 event beats clear");

    // R3 dma status with hole at bit 1
    evt('0, 9'h1FF);
    rd(A_DSTAT, 32'h1FD, "R3 dma latch, bit 1 absent");
    wr(A_DEN, 32'hFFFF_FFFF);
    rd(A_DEN, 32'h1FD, "R3 dma enable bit 1 absent");
    chk_irq(1'b0, "R7 masked dma keeps irq low");
    wr(A_DMASK, 32'hFFFF_FFFF);
    rd(A_DMASK, 32'h1, "R7 mask reads bit 0 only");
    chk_irq(1'b1, "R7 unmasked dma raises irq");
    wr(A_DMASK, 32'h0);
    chk_irq(1'b0, "R7 mask cleared");
    wr(A_DSTAT, 32'h0000_0005);
    rd(A_DSTAT, 32'h1F8, "R4 dma partial clear");
    wr(A_DSTAT, 32'hFFFF_FFFF);
    rd(A_DSTAT, 32'h0, "R4 dma clear all");

    // R9 / R10 unmapped address
    wr(A_HOLE, 32'hFFFF_FFFF);
    rd(A_HOLE, 32'h0, "R9 unmapped reads zero");
    rd(A_HSTAT, 32'h8, "R10 hash status untouched");
    rd(A_HEN,   32'h0, "R10 hash enable untouched");
    rd(A_DMASK, 32'h0, "R10 dma mask untouched");
    chk_irq(1'b0, "R10 irq untouched");

    // R6 hash alone raises irq, dma pending with mask set
    wr(A_HEN, 32'h8);
    chk_irq(1'b1, "R6 hash error enabled");
    wr(A_HSTAT, 32'h8);
    chk_irq(1'b0, "R6 cleared hash drops irq");
    wr(A_DMASK, 32'h1);
    evt('0, 9'h001);
    chk_irq(1'b1, "R6 dma done with mask set");

    repeat (4) cyc();
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R9: pending reads actual %0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule